// File: doc/BRIEF.md
# Recirculating Periodic Sorter

This block sorts a vector of `N` unsigned keys (N a power of two) into ascending order. Only one merging block is built in hardware. The block has `log2(N)` levels of compare-exchange elements. Its output is registered and fed back to its own input, one pass per clock, for exactly `log2(N)` passes. After the last pass the vector is fully sorted. The key count grows, but the comparator area stays at `(N/2)·log2(N)` elements instead of the `(N/2)·log2(N)²` that an unrolled network would need.

Inside the merging block, level k splits the lines into groups of `N >> k` lines. In each group, the line at offset i meets the line at offset `group-1-i`, and the smaller key leaves on the lower-numbered line. The caller drives all keys in parallel and pulses `start_i`, then waits for `done_o`. The sorted keys then stay on `keys_o` until the next sort finishes.

A controller with three states sequences the passes:
- **ST_IDLE** is entered at reset. An accepted start moves it to **ST_PASS** (transition *launch*).
- **ST_PASS** applies one pass each cycle. It stays there while the pass counter is below `log2(N)-1` (transition *recirculate*). On the last pass it moves to **ST_DONE** (transition *finish*).
- **ST_DONE** stays put until a start arrives (transition *hold*). A start returns it to **ST_PASS** (transition *relaunch*).

Top module: `recirc_sorter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy_o` and `done_o` are 0 and `keys_o` is all zeros.
- R2: A start sampled in ST_IDLE or ST_DONE captures `keys_i` and raises `busy_o` on the following cycle.
- R3: Exactly log2(N) passes are made. `done_o` rises, and `busy_o` falls, on the log2(N)-th clock edge after the edge that accepted start, whether or not the data was already sorted earlier.
- R4: When `done_o` is 1, `keys_o` holds the input keys in ascending unsigned order. Key j occupies bits `[j*W +: W]` of both `keys_i` and `keys_o`, and line 0 holds the smallest key.
- R5: Repeated keys are neither lost nor duplicated: the output multiset equals the input multiset. This includes the case where all keys are equal.
- R6: A start asserted while `busy_o` is 1 is ignored. Neither the pass timing nor the result changes, even if `keys_i` changes along with it.
- R7: `keys_o` changes only on the finishing pass. It holds its previous result through idle cycles and through all passes of a later sort, whatever `keys_i` does.
- R8: A start accepted in ST_DONE clears `done_o` on the next cycle and begins a new sort.
- R9: `busy_o` and `done_o` are never 1 together. `done_o` stays 1 until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a sort when the block is not busy |
| keys_i | input | N*W | Parallel unsorted keys, key j at bits [j*W +: W] |
| keys_o | output | N*W | Parallel sorted keys, ascending from key 0 |
| busy_o | output | 1 | Passes are in progress |
| done_o | output | 1 | keys_o holds a completed result |

## Verification
The assertions assume that `start_i` and `keys_i` are clean, synchronous levels. They also assume that the keys captured at launch are the only data the datapath ever sees, so checks on the sum and on the order can rely on the contents of the feedback register. The bench changes inputs only on falling edges and holds `rst_i` for several cycles before the first start. It also deliberately drives start pulses and new keys during busy periods and during done periods, so that the paths that must ignore them are actually exercised.

// File: rtl/recirc_sorter_pkg.sv
package recirc_sorter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DONE = 2'd2
    } sort_state_e;

endpackage

// File: rtl/cas_unit.sv
module cas_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);

    logic swap;

    always_comb begin
        swap = (a_i > b_i);
        lo_o = swap ? b_i : a_i;
        hi_o = swap ? a_i : b_i;
    end

endmodule

// File: rtl/merge_level.sv
module merge_level #(
    parameter int N   = 8,
    parameter int W   = 8,
    parameter int GRP = 8
) (
    input  logic [N*W-1:0] din_i,
    output logic [N*W-1:0] dout_o
);

    localparam int NGRP = N / GRP;
    localparam int HALF = GRP / 2;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar i = 0; i < HALF; i++) begin : g_pair
            localparam int LO = g * GRP + i;
            localparam int HI = g * GRP + GRP - 1 - i;
            cas_unit #(.W(W)) u_cas (
                .a_i  (din_i[LO*W +: W]),
                .b_i  (din_i[HI*W +: W]),
                .lo_o (dout_o[LO*W +: W]),
                .hi_o (dout_o[HI*W +: W])
            );
        end
    end

endmodule

// File: rtl/merge_block.sv
module merge_block #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic [N*W-1:0] din_i,
    output logic [N*W-1:0] dout_o
);

    localparam int LVL = $clog2(N);

    logic [LVL:0][N*W-1:0] stage;

    assign stage[0] = din_i;

    for (genvar k = 0; k < LVL; k++) begin : g_lvl
        merge_level #(.N(N), .W(W), .GRP(N >> k)) u_lvl (
            .din_i  (stage[k]),
            .dout_o (stage[k+1])
        );
    end

    assign dout_o = stage[LVL];

endmodule

// File: rtl/pass_ctrl.sv
module pass_ctrl
    import recirc_sorter_pkg::*;
#(
    parameter int PASSES = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(PASSES) + 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(PASSES - 1);

    sort_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_PASS;
                    cnt_d   = '0;
                end
            end
            ST_PASS: begin
                if (cnt_q == LAST_CNT) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                if (start_i) begin
                    state_d = ST_PASS;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        last_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_PASS: begin
                step_o = 1'b1;
                busy_o = 1'b1;
                last_o = (cnt_q == LAST_CNT);
            end
            ST_DONE: begin
                load_o = start_i;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R9: busy and done exclusive
    assert_busy_done_excl_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(busy_o && done_o));

    // R3: counter never exceeds the pass budget
    assert_pass_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> (cnt_q <= LAST_CNT));

    // R3: final pass leads straight to done
    assert_last_to_done_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && last_o) |=> (done_o && !busy_o));

    // R6: a start during a pass does not disturb the count
    assert_ignore_start_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !last_o) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

    // R9: done persists until a start arrives
    assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !start_i) |=> done_o);

    // R8: start from done relaunches
    assert_relaunch_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && start_i) |=> (busy_o && !done_o));

endmodule

// File: rtl/recirc_sorter.sv
module recirc_sorter #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           start_i,
    input  logic [N*W-1:0] keys_i,
    output logic [N*W-1:0] keys_o,
    output logic           busy_o,
    output logic           done_o
);

    localparam int PASSES = $clog2(N);
    localparam int SW     = W + $clog2(N) + 1;

    logic load, step, last;
    logic [N*W-1:0] work_q;
    logic [N*W-1:0] merged;
    logic [N*W-1:0] out_q;

    pass_ctrl #(.PASSES(PASSES)) u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    merge_block #(.N(N), .W(W)) u_merge (
        .din_i  (work_q),
        .dout_o (merged)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            work_q <= '0;
            out_q  <= '0;
        end else begin
            if (load) begin
                work_q <= keys_i;
            end else if (step) begin
                work_q <= merged;
            end
            if (last) begin
                out_q <= merged;
            end
        end
    end

    assign keys_o = out_q;

    logic          out_sorted;
    logic [SW-1:0] sum_work, sum_merged;

    always_comb begin
        out_sorted = 1'b1;
        for (int j = 1; j < N; j++) begin
            if (out_q[(j-1)*W +: W] > out_q[j*W +: W]) out_sorted = 1'b0;
        end
    end

    always_comb begin
        sum_work   = '0;
        sum_merged = '0;
        for (int j = 0; j < N; j++) begin
            sum_work   = sum_work   + SW'(work_q[j*W +: W]);
            sum_merged = sum_merged + SW'(merged[j*W +: W]);
        end
    end

    // R4: completed result is ascending
    assert_sorted_out_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> out_sorted);

    // R5: a pass conserves the key total
    assert_sum_kept_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> (sum_work == sum_merged));

    // R7: outputs frozen except on the finishing pass
    assert_hold_out_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(busy_o && last) |=> $stable(keys_o));

endmodule

// File: tb/tb_recirc_sorter.sv
module tb_recirc_sorter;

    localparam int N = 8;
    localparam int W = 8;
    localparam int L = $clog2(N);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N*W-1:0] keys_in = '0;
    logic [N*W-1:0] keys_out;
    logic           busy, done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    recirc_sorter #(.N(N), .W(W)) dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .keys_i  (keys_in),
        .keys_o  (keys_out),
        .busy_o  (busy),
        .done_o  (done)
    );

    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        logic [W-1:0] a [N];
        logic [W-1:0] t;
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
        for (int p = 0; p < N; p++) begin
            for (int i = 0; i < N - 1; i++) begin
                if (a[i] > a[i+1]) begin
                    t = a[i]; a[i] = a[i+1]; a[i+1] = t;
                end
            end
        end
        r = '0;
        for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input logic [N*W-1:0] act,
                         input logic [N*W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [N*W-1:0] prev_out;

    // Launch one sort and check timing, hold and result.
    task automatic run_sort(input logic [N*W-1:0] v, input string req,
                            input bit poke_busy);
        logic [N*W-1:0] exp;
        logic [N*W-1:0] other;
        logic           from_done;
        exp       = ref_sort(v);
        prev_out  = keys_out;
        from_done = done;
        @(negedge clk);
        keys_in = v;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", N*W'(busy), N*W'(1));
        if (from_done) check(done == 1'b0, "R8 done cleared", N*W'(done), '0);
        check(keys_out == prev_out, "R7 hold during pass", keys_out, prev_out);
        if (poke_busy) begin
            other   = {$urandom, $urandom};
            keys_in = other;
            start   = 1'b1;
        end
        for (int c = 0; c < L - 1; c++) begin
            @(negedge clk);
            start = 1'b0;
        end
        check(done == 1'b0 && busy == 1'b1, "R3 not done early",
              N*W'({busy, done}), N*W'(2'b10));
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R3 done on time",
              N*W'({busy, done}), N*W'(2'b01));
        check(keys_out == exp, req, keys_out, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [N*W-1:0] v;
        logic [N*W-1:0] held;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && keys_out == '0, "R1 reset state",
              keys_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && keys_out == '0, "R1 after reset",
              keys_out, '0);

        // Fixed patterns
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 17 + 3);
        run_sort(v, "R4 already sorted", 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(250 - i * 9);
        run_sort(v, "R4 reverse sorted", 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = 8'h5A;
        run_sort(v, "R5 all equal", 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(i % 3 == 0 ? 8'hFF : 8'h00);
        run_sort(v, "R5 extremes repeated", 1'b0);

        // 0/1-style sweep over every two-valued pattern
        for (int p = 0; p < (1 << N); p++) begin
            for (int i = 0; i < N; i++) v[i*W +: W] = p[i] ? 8'd200 : 8'd7;
            run_sort(v, "R4 two-valued sweep", 1'b0);
        end

        // Random vectors with duplicates likely in a narrow range
        for (int r = 0; r < 150; r++) begin
            v = {$urandom, $urandom};
            if (r % 2 == 1) begin
                for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom_range(0, 3));
            end
            run_sort(v, (r % 2 == 1) ? "R5 random duplicates" : "R4 random", 1'b0);
        end

        // Start and new keys while busy
        for (int r = 0; r < 20; r++) begin
            v = {$urandom, $urandom};
            run_sort(v, "R6 start while busy ignored", 1'b1);
        end

        // Hold after done while keys_in wanders
        held = keys_out;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            keys_in = {$urandom, $urandom};
        end
        @(negedge clk);
        check(keys_out == held, "R7 hold while done", keys_out, held);
        check(done == 1'b1 && busy == 1'b0, "R9 done persists",
              N*W'({busy, done}), N*W'(2'b01));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule